// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches a single external interrupt pin and turns it into an interrupt request. A two-bit sense-mode field selects what counts as an event: a low level, a falling edge or a rising edge. One code is reserved and never triggers. The edge modes pass the pin through a clocked synchronizer and latch the event in a sticky flag. The flag stays set until the interrupt acknowledge or a software write-one pulses the clear input.

Low-level mode keeps no flag. The request simply follows the pin while it is held low. A matching wake output is produced without any clock, so a low level can wake the system even when the I/O clock is gated off. If the low level disappears before the system has finished waking, the wake has already happened but no request remains.

An interrupt can also be raised from software. The block only looks at the pin value, so driving the pin from the chip's own output driver produces the same events.

Top module: `ext_irq_sense`

## Requirements
- R1: The mode field decodes as 00 = low level, 01 = reserved, 10 = falling edge, 11 = rising edge.
- R2: In falling-edge mode (10), a high-to-low change of the pin applied between clock edges sets the flag on the third rising clock edge after the change, and not before.
- R3: In rising-edge mode (11), a low-to-high change of the pin sets the flag on the third rising clock edge after the change, and a high-to-low change does not set it.
- R4: Once set, the flag stays set until the clear input is high at a rising clock edge; the flag is then low after that edge.
- R5: When a flag-setting edge and the clear input fall on the same clock edge, the set wins and the flag stays high.
- R6: In the edge modes the request equals enable AND flag; the flag is set by edges even while enable is low.
- R7: In low-level mode (00), the request is enable AND (pin low) without any clock delay, and the flag is never set.
- R8: The wake output is high exactly when enable is high, the mode is 00 and the pin is low. It responds while the clock is stopped, and it drops as soon as the pin returns high.
- R9: In reserved mode (01), no pin activity sets the flag, and the request and wake outputs stay low.
- R10: For SYNC_STAGES clock edges after the mode field changes (and after reset), edge detection is blanked, so a pin transition already inside the synchronizer does not set the flag.
- R11: Reset (synchronous, active high) clears the flag and leaves the request and wake outputs low for a high pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock, may be stopped |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw external interrupt pin |
| mode_i | input | 2 | Sense mode: 00 low, 01 reserved, 10 fall, 11 rise |
| enable_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Flag clear strobe (acknowledge or write-one) |
| irq_flag_o | output | 1 | Sticky edge flag |
| irq_req_o | output | 1 | Interrupt request to the controller |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The flag set from a detected edge and the flag clear strobe can land on the same clock edge. The bench provokes this by raising the clear input exactly on the third edge after a falling pin transition. That edge is the one on which the synchronized edge sets the flag. The flag is then expected high, and a following clear-only edge is expected to drop it. A second overlap, a mode change arriving with a pin transition, is judged by requiring that the flag stays low through the blanking window and that a later clean edge still sets it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSV  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_mode_e;

  function automatic logic is_edge_mode(input sense_mode_e m);
    return (m == SENSE_FALL) || (m == SENSE_RISE);
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b1;
          else     stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b1;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge
  import ext_irq_pkg::*;
#(
  parameter int BLANK_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sync_i,
  input  sense_mode_e mode_i,
  output logic        set_o
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] BLANK_LOAD = CW'(BLANK_CYCLES);

  logic        prev_q;
  sense_mode_e mode_q;
  logic [CW-1:0] blank_cnt_q;
  logic        mode_changed;
  logic        blank;
  logic        fell, rose;

  assign mode_changed = (mode_i != mode_q);
  assign blank        = mode_changed || (blank_cnt_q != '0);
  assign fell         = prev_q && !sync_i;
  assign rose         = !prev_q && sync_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= 1'b1;
      mode_q      <= SENSE_LOW;
      blank_cnt_q <= BLANK_LOAD;
    end else begin
      prev_q <= sync_i;
      mode_q <= mode_i;
      if (mode_changed)           blank_cnt_q <= BLANK_LOAD;
      else if (blank_cnt_q != '0) blank_cnt_q <= blank_cnt_q - 1'b1;
    end
  end

  always_comb begin
    set_o = 1'b0;
    if (!blank) begin
      unique case (mode_i)
        SENSE_FALL: set_o = fell;
        SENSE_RISE: set_o = rose;
        default:    set_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       enable_i,
  input  logic       flag_clr_i,
  output logic       irq_flag_o,
  output logic       irq_req_o,
  output logic       wake_o
);
  sense_mode_e mode;
  logic        pin_sync;
  logic        edge_set;
  logic        level_hit;

  assign mode = sense_mode_e'(mode_i);

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_sync)
  );

  ext_irq_edge #(.BLANK_CYCLES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sync_i (pin_sync),
    .mode_i (mode),
    .set_o  (edge_set)
  );

  ext_irq_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (edge_set),
    .clr_i  (flag_clr_i),
    .flag_o (irq_flag_o)
  );

  // Level path: no clock involved, usable while the clock is gated off.
  assign level_hit = enable_i && (mode == SENSE_LOW) && !pin_i;
  assign wake_o    = level_hit;

  always_comb begin
    if (mode == SENSE_LOW)   irq_req_o = level_hit;
    else if (is_edge_mode(mode)) irq_req_o = enable_i && irq_flag_o;
    else                     irq_req_o = 1'b0;
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk (
  input logic       clk,
  input logic       rst,
  input logic       pin_i,
  input logic [1:0] mode_i,
  input logic       enable_i,
  input logic       flag_clr_i,
  input logic       irq_flag_o,
  input logic       irq_req_o,
  input logic       wake_o
);
  // R9
  flag_rise_needs_edge_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag_o) |-> $past(mode_i[1]));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !mode_i[1]) |=> !irq_flag_o);

  // R8
  wake_implies_req_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (irq_req_o && !pin_i));

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b01) |-> (!irq_req_o && !wake_o));

  // R6
  enable_masks_chk: assert property (@(posedge clk) disable iff (rst)
    !enable_i |-> (!irq_req_o && !wake_o));

  // R10
  mode_change_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i != $past(mode_i)) |=> !$rose(irq_flag_o));
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pin_i      (pin_i),
  .mode_i     (mode_i),
  .enable_i   (enable_i),
  .flag_clr_i (flag_clr_i),
  .irq_flag_o (irq_flag_o),
  .irq_req_o  (irq_req_o),
  .wake_o     (wake_o)
);

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/1ps
module ext_irq_sense_test;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst;
  logic       pin;
  logic [1:0] mode;
  logic       en;
  logic       clr;
  logic       flag, req, wake;
  int         n_checks = 0;
  int         n_fails  = 0;
  bit         done = 1'b0;

  always #2 clk = clk_run ? ~clk : clk;

  ext_irq_sense #(.SYNC_STAGES(2)) uut (
    .clk (clk), .rst (rst), .pin_i (pin), .mode_i (mode),
    .enable_i (en), .flag_clr_i (clr),
    .irq_flag_o (flag), .irq_req_o (req), .wake_o (wake)
  );

  task automatic check(input logic act, input logic exp, input string req_tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req_tag, what, act, exp);
    end
  endtask

  task automatic after_pos(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    after_pos(4);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; pin = 1'b1; mode = 2'b10; en = 1'b1; clr = 1'b0;
    after_pos(3);
    @(negedge clk); rst = 1'b0;
    after_pos(4);
    check(flag, 1'b0, "R11", "flag after reset");
    check(req,  1'b0, "R11", "request after reset");
    check(wake, 1'b0, "R11", "wake after reset");
  endtask

  task automatic t_falling();
    set_mode(2'b10);
    @(negedge clk); pin = 1'b0;
    after_pos(2);
    check(flag, 1'b0, "R2", "falling flag before third edge");
    after_pos(1);
    check(flag, 1'b1, "R2", "falling flag on third edge");
    check(req,  1'b1, "R6", "request follows flag when enabled");
  endtask

  task automatic t_clear();
    after_pos(3);
    check(flag, 1'b1, "R4", "flag sticky without clear");
    @(negedge clk); clr = 1'b1;
    after_pos(1);
    check(flag, 1'b0, "R4", "flag cleared by strobe");
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_rising();
    set_mode(2'b11);
    clear_flag();
    @(negedge clk); pin = 1'b1;
    after_pos(2);
    check(flag, 1'b0, "R3", "rising flag before third edge");
    after_pos(1);
    check(flag, 1'b1, "R3", "rising flag on third edge");
    clear_flag();
    @(negedge clk); pin = 1'b0;
    after_pos(5);
    check(flag, 1'b0, "R3", "falling pin ignored in rising mode");
  endtask

  task automatic t_collide();
    set_mode(2'b10);
    @(negedge clk); pin = 1'b1;
    after_pos(4);
    clear_flag();
    @(negedge clk); pin = 1'b0;
    after_pos(2);
    @(negedge clk); clr = 1'b1;
    after_pos(1);
    check(flag, 1'b1, "R5", "set wins over clear on same edge");
    after_pos(1);
    check(flag, 1'b0, "R5", "later clear-only edge drops flag");
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_enable();
    @(negedge clk); en = 1'b0; pin = 1'b1;
    after_pos(4);
    clear_flag();
    @(negedge clk); pin = 1'b0;
    after_pos(3);
    check(flag, 1'b1, "R6", "flag sets while disabled");
    check(req,  1'b0, "R6", "request masked while disabled");
    @(negedge clk); en = 1'b1; #1;
    check(req,  1'b1, "R6", "request appears on enable");
    clear_flag();
  endtask

  task automatic t_level();
    @(negedge clk); pin = 1'b1;
    set_mode(2'b00);
    clear_flag();
    @(negedge clk); pin = 1'b0; #1;
    check(req,  1'b1, "R7", "level request without clock delay");
    after_pos(4);
    check(flag, 1'b0, "R7", "no flag in level mode");
    check(wake, 1'b1, "R8", "wake while pin low");
    @(negedge clk); pin = 1'b1; #1;
    check(req,  1'b0, "R7", "level request drops with pin");
  endtask

  task automatic t_wake_noclk();
    @(negedge clk); clk_run = 1'b0;
    #20 pin = 1'b0; #1;
    check(wake, 1'b1, "R8", "wake with clock stopped");
    #10 pin = 1'b1; #1;
    check(wake, 1'b0, "R8", "wake drops when level leaves");
    check(req,  1'b0, "R8", "no request once level gone");
    #5 clk_run = 1'b1;
  endtask

  task automatic t_reserved();
    set_mode(2'b01);
    @(negedge clk); pin = 1'b0; #1;
    check(wake, 1'b0, "R9", "no wake in reserved mode");
    after_pos(4);
    @(negedge clk); pin = 1'b1;
    after_pos(4);
    check(flag, 1'b0, "R9", "no flag in reserved mode");
    check(req,  1'b0, "R1", "reserved code requests nothing");
  endtask

  task automatic t_modechange();
    @(negedge clk); pin = 1'b0; mode = 2'b10;
    after_pos(5);
    check(flag, 1'b0, "R10", "in-flight edge blanked after mode change");
    @(negedge clk); pin = 1'b1;
    after_pos(4);
    @(negedge clk); pin = 1'b0;
    after_pos(3);
    check(flag, 1'b1, "R10", "detection resumes after blanking");
  endtask

  initial begin
    t_reset();
    t_falling();
    t_clear();
    t_rising();
    t_collide();
    t_enable();
    t_level();
    t_wake_noclk();
    t_reserved();
    t_modechange();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule